// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator Bank

This block generates up to eight independent pulse-width modulated outputs. Each channel has a power-of-two prescaler, a 13-bit period counter and a 13-bit high-time compare. Software reaches the block over a simple 32-bit register bus. Each access has an address, a write strobe and write data. Read data comes back from a register in the cycle after the address. One shared bitmap register starts and stops the channels. Every channel has its own register window, placed at a fixed stride, that holds its divider exponent, its period and its threshold.

Period and threshold are stored as value-minus-one. A channel with exponent `e`, period field `P` and threshold field `T` repeats every `(P+1) << e` clocks. Its output is high for the first `(T+1)` ticks of each cycle. Configuration written while a channel runs is held in the register bank and copied into the channel only when its current cycle ends, so no pulse is ever cut short. A build parameter selects a second layout in which channels with an index above 2 find their period and threshold registers four bytes higher in their window.

Top module: `pwm_bank`

## Requirements
- R1: After reset all outputs are low and every register reads zero.
- R2: Address 0x00 is the enable bitmap: bit n runs channel n. Bits at or above the channel count are not stored and read zero.
- R3: Channel n's window starts at 0x10 + n*0x40. Its control register at window offset 0x00 holds the divider exponent in bits [2:0] and a flag in bit 15. Both are stored as written and every other bit reads zero.
- R4: The period register sits at window offset 0x2C and the threshold register at 0x30. Both keep and return only the low 13 bits of the written data.
- R5: With the alternate layout parameter set, channels with index above 2 have their period at window offset 0x30 and their threshold at 0x34. Lower channels keep 0x2C and 0x30.
- R6: Addresses that map to no register read zero, and writes to them change neither the registers nor the outputs.
- R7: Read data is registered. It reflects the address presented in the previous cycle and does not change until the next clock edge.
- R8: A running channel with exponent e, period P and threshold T repeats every (P+1)<<e clocks. Its output is high for the first (T+1)<<e clocks of each cycle.
- R9: When T is greater than or equal to P, the output of a running channel stays high.
- R10: A disabled channel drives its output low. On the clock edge that sets its enable bit it starts a fresh cycle with the output high.
- R11: Exponent, period or threshold written while a channel runs take effect only at the start of that channel's next cycle.
- R12: Channels run independently of each other, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_we | input | 1 | Write strobe; data is written on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented in the previous cycle |
| pwm_out | output | NUM_CH (8) | One pulse output per channel |

## Verification
The assertions assume that the bus holds its address and data stable around each rising edge. They also assume that the reset is held for at least two clocks, so the internal synchronizer has cleared before any access. The bench drives every bus input on the falling edge and raises the write strobe for exactly one rising edge per access. It waits out the synchronizer before the first access. Mid-cycle reconfiguration is driven at known sample indices, well away from the cycle boundary. This keeps the hand-computed waveforms unambiguous about which edge copies the new settings.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EXP_W    = 3;
  localparam int unsigned CNT_W    = 13;
  localparam int unsigned PRE_W    = (1 << EXP_W) - 1;
  localparam int unsigned FLAG_BIT = 15;

  localparam int unsigned OFS_CTRL     = 'h00;
  localparam int unsigned OFS_PER      = 'h2C;
  localparam int unsigned OFS_THR      = 'h30;
  localparam int unsigned OFS_PER_ALT  = 'h30;
  localparam int unsigned OFS_THR_ALT  = 'h34;
  localparam int unsigned ALT_FIRST_CH = 3;

  typedef struct packed {
    logic             flag;
    logic [EXP_W-1:0] expo;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] thr;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_bank_rst_sync.sv
module pwm_bank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WIN_BASE   = 'h10,
  parameter int unsigned WIN_STRIDE = 'h40,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [NUM_CH-1:0]      ch_run,
  output chan_cfg_t [NUM_CH-1:0] ch_cfg
);

  localparam logic [ADDR_W-1:0] ENA_ADDR = '0;

  logic [ADDR_W-1:0] ctrl_a [NUM_CH];
  logic [ADDR_W-1:0] per_a  [NUM_CH];
  logic [ADDR_W-1:0] thr_a  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    localparam int unsigned WIN   = WIN_BASE + g * WIN_STRIDE;
    localparam bit          MOVED = ALT_LAYOUT && (g >= ALT_FIRST_CH);
    if (MOVED) begin : g_alt
      assign per_a[g] = ADDR_W'(WIN + OFS_PER_ALT);
      assign thr_a[g] = ADDR_W'(WIN + OFS_THR_ALT);
    end else begin : g_std
      assign per_a[g] = ADDR_W'(WIN + OFS_PER);
      assign thr_a[g] = ADDR_W'(WIN + OFS_THR);
    end
    assign ctrl_a[g] = ADDR_W'(WIN + OFS_CTRL);
  end

  logic [NUM_CH-1:0]      en_q, en_d;
  chan_cfg_t [NUM_CH-1:0] cfg_q, cfg_d;
  logic [DATA_W-1:0]      rd_q, rd_d;
  logic                   hit;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    en_d  = en_q;
    cfg_d = cfg_q;
    rd_d  = '0;
    hit   = 1'b0;
    if (bus_addr == ENA_ADDR) begin
      hit                = 1'b1;
      rd_d[NUM_CH-1:0]   = en_q;
      en_d               = bus_wdata[NUM_CH-1:0];
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ctrl_a[i]) begin
        hit                  = 1'b1;
        rd_d[FLAG_BIT]       = cfg_q[i].flag;
        rd_d[EXP_W-1:0]      = cfg_q[i].expo;
        cfg_d[i].flag        = bus_wdata[FLAG_BIT];
        cfg_d[i].expo        = bus_wdata[EXP_W-1:0];
      end
      if (bus_addr == per_a[i]) begin
        hit                  = 1'b1;
        rd_d[CNT_W-1:0]      = cfg_q[i].per;
        cfg_d[i].per         = bus_wdata[CNT_W-1:0];
      end
      if (bus_addr == thr_a[i]) begin
        hit                  = 1'b1;
        rd_d[CNT_W-1:0]      = cfg_q[i].thr;
        cfg_d[i].thr         = bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
      rd_q  <= '0;
    end else begin
      rd_q <= rd_d;
      if (bus_we) begin
        en_q  <= en_d;
        cfg_q <= cfg_d;
      end
    end
  end

  assign bus_rdata = rd_q;
  assign ch_run    = en_q;
  assign ch_cfg    = cfg_q;

  // R2: a write to the bitmap address lands in the enable register
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ENA_ADDR) |=> (ch_run == $past(bus_wdata[NUM_CH-1:0])));

  // R6: a write that decodes to nothing leaves all state alone
  a_r6_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> ($stable(ch_run) && $stable(ch_cfg)));

  // R6: an unmapped read returns zero
  a_r6_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> (bus_rdata == '0));

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EXP_W-1:0] expo_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             pwm_o
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] thr_q, thr_d;
  logic [PRE_W-1:0] pre_mask;
  logic             tick;
  logic             wrap;

  assign pre_mask = ~({PRE_W{1'b1}} << exp_q);
  assign tick     = (pre_q == pre_mask);
  assign wrap     = tick && (cnt_q == per_q);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    exp_d = exp_q;
    per_d = per_q;
    thr_d = thr_q;
    if (!run_i) begin
      pre_d = '0;
      cnt_d = '0;
      exp_d = expo_i;
      per_d = per_i;
      thr_d = thr_i;
    end else if (tick) begin
      pre_d = '0;
      if (wrap) begin
        cnt_d = '0;
        exp_d = expo_i;
        per_d = per_i;
        thr_d = thr_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      exp_q <= '0;
      per_q <= '0;
      thr_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      exp_q <= exp_d;
      per_q <= per_d;
      thr_q <= thr_d;
    end
  end

  assign pwm_o = run_i && (cnt_q <= thr_q);

  // R10: while stopped, the prescaler and counter are held at zero
  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (cnt_q == '0 && pre_q == '0));

  // R11: active settings change only at a cycle boundary
  a_r11_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap) |=> ($stable(exp_q) && $stable(per_q) && $stable(thr_q)));

  // R8: the counter never passes the active period
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= per_q));

  // R8: the prescaler never passes its active mask
  a_r8_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pre_q <= pre_mask));

  // R9: threshold at or above period means a constant high output
  a_r9_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && thr_q >= per_q) |-> pwm_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned WIN_BASE   = 'h10,
  parameter int unsigned WIN_STRIDE = 'h40,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic                   rst_sync_n;
  logic [NUM_CH-1:0]      ch_run;
  chan_cfg_t [NUM_CH-1:0] ch_cfg;
  logic                   unused_flags;

  pwm_bank_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_bank_regs #(
    .NUM_CH     (NUM_CH),
    .ADDR_W     (ADDR_W),
    .WIN_BASE   (WIN_BASE),
    .WIN_STRIDE (WIN_STRIDE),
    .ALT_LAYOUT (ALT_LAYOUT)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_run    (ch_run),
    .ch_cfg    (ch_cfg)
  );

  logic [NUM_CH-1:0] flag_bits;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign flag_bits[c] = ch_cfg[c].flag;
    pwm_bank_chan i_chan (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .run_i  (ch_run[c]),
      .expo_i (ch_cfg[c].expo),
      .per_i  (ch_cfg[c].per),
      .thr_i  (ch_cfg[c].thr),
      .pwm_o  (pwm_out[c])
    );
  end

  assign unused_flags = ^flag_bits;

endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        we_m, we_a;
  logic [31:0] bus_wdata;
  logic [31:0] rd_m, rd_a;
  logic [7:0]  out_m;
  logic [4:0]  out_a;
  int checks = 0;
  int errors = 0;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_m),
    .bus_wdata(bus_wdata), .bus_rdata(rd_m), .pwm_out(out_m));

  pwm_bank #(.NUM_CH(5), .ALT_LAYOUT(1'b1)) i_pwm_bank_alt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(we_a),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pwm_out(out_a));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [11:0] ctrl_adr(int n);
    return 12'(16 + n * 64);
  endfunction
  function automatic logic [11:0] per_adr(int n, bit alt);
    return 12'(16 + n * 64 + ((alt && n > 2) ? 'h30 : 'h2C));
  endfunction
  function automatic logic [11:0] thr_adr(int n, bit alt);
    return 12'(16 + n * 64 + ((alt && n > 2) ? 'h34 : 'h30));
  endfunction
  function automatic bit wave(int k, int e, int p, int t);
    return ((k >> e) % (p + 1)) <= t;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit alt, logic [11:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    if (alt) we_a = 1'b1; else we_m = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we_a = 1'b0;
    we_m = 1'b0;
  endtask

  task automatic rd(bit alt, logic [11:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, alt ? rd_a : rd_m, exp);
  endtask

  task automatic cfg_ch(bit alt, int n, int e, int p, int t);
    wr(alt, ctrl_adr(n), 32'h8000 | 32'(e));
    wr(alt, per_adr(n, alt), 32'(p));
    wr(alt, thr_adr(n, alt), 32'(t));
  endtask

  // configure, enable, compare nsamp samples from the enable edge onward
  task automatic run_wave(bit alt, int n, int e, int p, int t, int nsamp, string tag);
    int bad = 0;
    int bad_k = 0;
    bit bad_act = 0;
    bit bad_exp = 0;
    cfg_ch(alt, n, e, p, t);
    wr(alt, 12'h000, 32'(1) << n);
    for (int k = 0; k < nsamp; k++) begin
      bit o = alt ? out_a[n] : out_m[n];
      bit x = wave(k, e, p, t);
      if (o !== x) begin
        if (bad == 0) begin bad_k = k; bad_act = o; bad_exp = x; end
        bad++;
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: sample %0d actual %0b expected %0b", tag, bad_k, bad_act, bad_exp);
    end
    wr(alt, 12'h000, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 main outputs", 32'(out_m), 32'h0);
    chk("R1 alt outputs", 32'(out_a), 32'h0);
    rd(0, 12'h000, 32'h0, "R1 enable");
    rd(0, ctrl_adr(0), 32'h0, "R1 ctrl0");
    rd(0, per_adr(7, 0), 32'h0, "R1 per7");
    rd(0, thr_adr(7, 0), 32'h0, "R1 thr7");
  endtask

  task automatic t_enable_reg;
    wr(1, 12'h000, 32'hFFFF_FFFF);
    rd(1, 12'h000, 32'h1F, "R2 alt bitmap width");
    chk("R2 alt outputs run", 32'(out_a), 32'h1F);
    wr(1, 12'h000, 32'h0);
    wr(0, 12'h000, 32'hA5);
    rd(0, 12'h000, 32'hA5, "R2 main bitmap");
    wr(0, 12'h000, 32'h0);
  endtask

  task automatic t_ctrl_reg;
    wr(0, ctrl_adr(6), 32'hFFFF_FFFF);
    rd(0, ctrl_adr(6), 32'h8007, "R3 ctrl all ones");
    wr(0, ctrl_adr(6), 32'h0000_0005);
    rd(0, ctrl_adr(6), 32'h5, "R3 flag cleared");
  endtask

  task automatic t_per_thr_reg;
    wr(0, per_adr(1, 0), 32'hFFFF_FFFF);
    rd(0, per_adr(1, 0), 32'h1FFF, "R4 period mask");
    wr(0, thr_adr(1, 0), 32'hABCD_1234);
    rd(0, thr_adr(1, 0), 32'h1234, "R4 threshold mask");
  endtask

  task automatic t_alt_layout;
    cfg_ch(1, 3, 0, 'h123, 'h45);
    rd(1, 12'h100, 32'h123, "R5 alt ch3 period");
    rd(1, 12'h104, 32'h45, "R5 alt ch3 threshold");
    cfg_ch(1, 2, 0, 'h77, 'h11);
    rd(1, 12'h0BC, 32'h77, "R5 alt ch2 period");
    cfg_ch(0, 3, 0, 'hAB, 'hCD);
    rd(0, 12'h0FC, 32'hAB, "R5 std ch3 period");
    rd(0, 12'h100, 32'hCD, "R5 std ch3 threshold");
    run_wave(1, 3, 0, 3, 1, 24, "R5 alt ch3 waveform");
  endtask

  task automatic t_unmapped;
    wr(0, 12'h004, 32'hFF);
    wr(0, 12'h014, 32'hFFFF);
    rd(0, 12'h000, 32'h0, "R6 enable untouched");
    chk("R6 outputs untouched", 32'(out_m), 32'h0);
    rd(0, 12'h004, 32'h0, "R6 gap reads zero");
    rd(0, 12'h014, 32'h0, "R6 window gap reads zero");
  endtask

  task automatic t_read_latency;
    wr(0, ctrl_adr(0), 32'h8003);
    rd(0, ctrl_adr(0), 32'h8003, "R7 first read");
    bus_addr = per_adr(1, 0);
    #1;
    chk("R7 no combinational path", rd_m, 32'h8003);
    @(posedge clk);
    @(negedge clk);
    chk("R7 next cycle", rd_m, 32'h1FFF);
  endtask

  task automatic t_disable_restart;
    cfg_ch(0, 1, 1, 7, 2);
    wr(0, 12'h000, 32'h2);
    repeat (11) @(negedge clk);
    wr(0, 12'h000, 32'h0);
    for (int k = 0; k < 6; k++) begin
      chk("R10 disabled low", 32'(out_m[1]), 32'h0);
      @(negedge clk);
    end
    run_wave(0, 1, 1, 7, 2, 48, "R10 fresh start");
  endtask

  task automatic t_independent;
    int bad = 0;
    cfg_ch(0, 2, 0, 5, 2);
    cfg_ch(0, 5, 1, 3, 0);
    wr(0, 12'h000, 32'h24);
    for (int k = 0; k < 40; k++) begin
      if (out_m[2] !== wave(k, 0, 5, 2)) bad++;
      if (out_m[5] !== wave(k, 1, 3, 0)) bad++;
      if ((out_m & 8'hDB) !== 8'h00) bad++;
      @(negedge clk);
    end
    chk("R12 two channels", 32'(bad), 32'h0);
    wr(0, 12'h000, 32'h0);
  endtask

  task automatic t_boundary;
    int bad = 0;
    cfg_ch(0, 0, 0, 9, 3);
    wr(0, 12'h000, 32'h1);
    for (int k = 0; k < 30; k++) begin
      bit x = (k < 10) ? wave(k, 0, 9, 3) : wave(k - 10, 0, 4, 1);
      if (out_m[0] !== x) bad++;
      if (k == 4) begin bus_addr = per_adr(0, 0); bus_wdata = 32'd4; we_m = 1'b1; end
      if (k == 5) begin bus_addr = thr_adr(0, 0); bus_wdata = 32'd1; end
      if (k == 6) we_m = 1'b0;
      @(negedge clk);
    end
    chk("R11 update at boundary", 32'(bad), 32'h0);
    wr(0, 12'h000, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    we_m      = 1'b0;
    we_a      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    t_reset();
    t_enable_reg();
    t_ctrl_reg();
    t_per_thr_reg();
    t_unmapped();
    t_read_latency();
    t_alt_layout();
    run_wave(0, 0, 0, 9, 3, 30, "R8 exp0");
    run_wave(0, 4, 2, 4, 1, 60, "R8 exp2");
    run_wave(0, 6, 3, 2, 0, 60, "R8 min threshold");
    run_wave(0, 7, 7, 1, 0, 600, "R8 max exponent");
    run_wave(0, 3, 0, 6, 6, 30, "R9 threshold equal");
    run_wave(0, 3, 2, 6, 100, 40, "R9 threshold above");
    t_disable_restart();
    t_independent();
    t_boundary();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule